// File: doc/BRIEF.md
# Flash Busy Status Read Generator

This block stands in for the status path of a NOR-style flash array while an internal word program or erase runs. A one-cycle start pulse carries the operation type (word program, sector erase, block erase or chip erase) and bit 7 of the word being programmed. The start pulse corresponds to the rising edge of the last write of the command sequence: the fourth write for a program, the sixth for any erase. From then on a cycle-count timer holds the block busy for a duration set per operation type. While busy, every host read strobe is answered with two status bits instead of array data. One is an inverted-data bit whose meaning depends on the operation. The other flips on each read.

When the timer expires the block drops busy and pulses done for one clock. After a word program there is a short settle window of a parameterised number of cycles. In that window the inverted-data bit already shows the true value, but the remaining bits still carry stale contents. After that, and directly after any erase, reads pass the array word through. The command decoder and the storage array sit outside this block. The array word arrives on an input and is returned on reads once the block is idle. Busy durations are parameters in clock cycles, scaled down from the microsecond and millisecond times of real parts.

Top module: `flash_busy_status`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `rdata_o` is all zeros.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle. `busy_o` stays high for exactly PROG_CYC, SECT_CYC, BLK_CYC or CHIP_CYC cycles for `op_i` = 0 (word program), 1 (sector erase), 2 (block erase) or 3 (chip erase).
- R3: `done_o` is high for exactly one cycle: the first cycle after `busy_o` falls.
- R4: A read during a word program returns bit 7 of `rdata_o` as the complement of `prog_bit_i` captured at start.
- R5: A read during any erase returns bit 7 of `rdata_o` as 0.
- R6: Bit 6 of `rdata_o` is cleared at start. It inverts on every read made while busy, so the first busy read returns 1. Clock cycles without a read do not advance it.
- R7: A read while busy leaves bits 15:8 and 5:0 of `rdata_o` at their previous values, whatever `array_i` carries.
- R8: For SETTLE_CYC cycles after a word program ends, a read returns bit 7 equal to the captured `prog_bit_i`, bit 6 frozen at its last value, and the other bits unchanged.
- R9: A read when neither busy nor settling returns `array_i` on all bits.
- R10: A `start_i` pulse while busy is ignored: the running operation's length, its bit-7 status and its toggle sequence are unaffected.
- R11: `rdata_o` changes only on the cycle after a cycle in which `rd_i` was high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse launching an internal operation |
| op_i | input | 2 | Operation: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| prog_bit_i | input | 1 | Bit 7 of the word being programmed |
| rd_i | input | 1 | Host read strobe, one per read cycle |
| array_i | input | 16 | Array word at the addressed location |
| rdata_o | output | 16 | Registered read data, updated the cycle after a strobe |
| busy_o | output | 1 | High while the internal operation runs |
| done_o | output | 1 | One-cycle pulse when the operation finishes |

## Verification
The bench goes after the edges of the busy window. A timer off by one shows up as a busy length one cycle wrong, or as a done pulse that is late or two cycles wide. It also tests a second start arriving on the very last busy cycle; a design that accepted it would restart the timer and double the busy length. Read strobes are spread irregularly, so a toggle bit that advanced on the clock instead of on reads gives the wrong phase. Each read is checked bit-field by bit-field. This catches a program and erase swapped in bit 7, array bits leaking through while busy, and a missing or misplaced settle window, which would expose the array word too early or hold stale bits after an erase.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef enum logic [1:0] {
        FBS_PROG = 2'd0,
        FBS_SECT = 2'd1,
        FBS_BLK  = 2'd2,
        FBS_CHIP = 2'd3
    } fbs_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } fbs_phase_e;

    typedef struct packed {
        fbs_op_e op;
        logic    wbit;
    } fbs_job_t;

    localparam int unsigned POLL_BIT   = 7;
    localparam int unsigned TOGGLE_BIT = 6;

    function automatic logic is_erase(input fbs_op_e op);
        return op != FBS_PROG;
    endfunction

    // Value of the inverted-data bit while the job is still running
    function automatic logic busy_poll(input fbs_job_t job);
        return is_erase(job.op) ? 1'b0 : ~job.wbit;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fbs_timer.sv
module fbs_timer
    import fbs_pkg::*;
#(
    parameter int unsigned PROG_CYC = 40,
    parameter int unsigned SECT_CYC = 90,
    parameter int unsigned BLK_CYC  = 100,
    parameter int unsigned CHIP_CYC = 160,
    localparam int unsigned MAX_CYC = max4(PROG_CYC, SECT_CYC, BLK_CYC, CHIP_CYC),
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  fbs_op_e  op_i,
    input  logic     wbit_i,
    output logic     accept_o,
    output logic     finish_o,
    output logic     busy_o,
    output logic     done_o,
    output fbs_job_t job_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    fbs_job_t         job_q;

    function automatic logic [CNT_W-1:0] last_tick(input fbs_op_e op);
        case (op)
            FBS_PROG: return CNT_W'(PROG_CYC - 1);
            FBS_SECT: return CNT_W'(SECT_CYC - 1);
            FBS_BLK:  return CNT_W'(BLK_CYC - 1);
            default:  return CNT_W'(CHIP_CYC - 1);
        endcase
    endfunction

    assign accept_o = start_i && !busy_q;
    assign finish_o = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            job_q  <= '{op: FBS_PROG, wbit: 1'b0};
        end else begin
            done_q <= 1'b0;
            if (accept_o) begin
                busy_q <= 1'b1;
                cnt_q  <= last_tick(op_i);
                job_q  <= '{op: op_i, wbit: wbit_i};
            end else if (finish_o) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign job_o  = job_q;

    a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
        busy_q && cnt_q != '0 |=> busy_q);
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r3_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
        finish_o |=> done_q && !busy_q);
    a_r10_job_kept: assert property (@(posedge clk) disable iff (rst)
        busy_q && start_i && !finish_o |=> $stable(job_q) && busy_q);

endmodule

// File: rtl/fbs_settle.sv
module fbs_settle
    import fbs_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 3,
    localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1) + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  logic     finish_i,
    input  fbs_job_t job_i,
    output logic     settle_o
);

    generate
        if (SETTLE_CYC == 0) begin : g_none
            logic unused_in;
            assign unused_in = clk ^ rst ^ accept_i ^ finish_i ^ (^job_i);
            assign settle_o  = 1'b0;
        end else begin : g_cnt
            logic [SET_W-1:0] left_q;

            always_ff @(posedge clk) begin
                if (rst || accept_i) begin
                    left_q <= '0;
                end else if (finish_i && !is_erase(job_i.op)) begin
                    left_q <= SET_W'(SETTLE_CYC);
                end else if (left_q != '0) begin
                    left_q <= left_q - 1'b1;
                end
            end

            assign settle_o = (left_q != '0);

            a_r8_settle_after_prog: assert property (@(posedge clk) disable iff (rst)
                finish_i && !is_erase(job_i.op) |=> settle_o);
            a_r9_no_settle_after_erase: assert property (@(posedge clk) disable iff (rst)
                finish_i && is_erase(job_i.op) |=> !settle_o);
        end
    endgenerate

endmodule

// File: rtl/fbs_toggle.sv
module fbs_toggle (
    input  logic clk,
    input  logic rst,
    input  logic accept_i,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_o
);

    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst || accept_i) begin
            tog_q <= 1'b0;
        end else if (rd_i && busy_i) begin
            tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

    a_r6_cleared_on_start: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> !tog_q);
    a_r6_still_without_read: assert property (@(posedge clk) disable iff (rst)
        !rd_i && !accept_i |=> $stable(tog_q));
    a_r6_flips_on_read: assert property (@(posedge clk) disable iff (rst)
        rd_i && busy_i && !accept_i |=> tog_q != $past(tog_q));

endmodule

// File: rtl/fbs_readmux.sv
module fbs_readmux
    import fbs_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  fbs_phase_e        phase_i,
    input  fbs_job_t          job_i,
    input  logic              tog_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = rdata_q;
        case (phase_i)
            PH_BUSY: begin
                rdata_d[POLL_BIT]   = busy_poll(job_i);
                rdata_d[TOGGLE_BIT] = ~tog_i;
            end
            PH_SETTLE: begin
                rdata_d[POLL_BIT]   = job_i.wbit;
                rdata_d[TOGGLE_BIT] = tog_i;
            end
            default: rdata_d = array_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

    a_r11_hold_without_read: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rdata_q));
    a_r7_upper_stale: assert property (@(posedge clk) disable iff (rst)
        rd_i && phase_i == PH_BUSY |=> $stable(rdata_q[DATA_W-1:POLL_BIT+1]));
    a_r5_erase_poll_low: assert property (@(posedge clk) disable iff (rst)
        rd_i && phase_i == PH_BUSY && is_erase(job_i.op) |=> !rdata_q[POLL_BIT]);

endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import fbs_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned PROG_CYC   = 40,
    parameter int unsigned SECT_CYC   = 90,
    parameter int unsigned BLK_CYC    = 100,
    parameter int unsigned CHIP_CYC   = 160,
    parameter int unsigned SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              prog_bit_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o
);

    logic       accept;
    logic       finish;
    logic       busy;
    logic       settle;
    logic       tog;
    fbs_job_t   job;
    fbs_phase_e phase;

    fbs_timer #(
        .PROG_CYC (PROG_CYC),
        .SECT_CYC (SECT_CYC),
        .BLK_CYC  (BLK_CYC),
        .CHIP_CYC (CHIP_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .op_i     (fbs_op_e'(op_i)),
        .wbit_i   (prog_bit_i),
        .accept_o (accept),
        .finish_o (finish),
        .busy_o   (busy),
        .done_o   (done_o),
        .job_o    (job)
    );

    fbs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .finish_i (finish),
        .job_i    (job),
        .settle_o (settle)
    );

    fbs_toggle u_toggle (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .busy_i   (busy),
        .rd_i     (rd_i),
        .tog_o    (tog)
    );

    always_comb begin
        if (busy)        phase = PH_BUSY;
        else if (settle) phase = PH_SETTLE;
        else             phase = PH_IDLE;
    end

    fbs_readmux #(.DATA_W(DATA_W)) u_readmux (
        .clk     (clk),
        .rst     (rst),
        .rd_i    (rd_i),
        .phase_i (phase),
        .job_i   (job),
        .tog_i   (tog),
        .array_i (array_i),
        .rdata_o (rdata_o)
    );

    assign busy_o = busy;

    a_r2_busy_rises: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy |=> busy_o);
    a_r4_prog_poll_inverted: assert property (@(posedge clk) disable iff (rst)
        rd_i && busy && job.op == FBS_PROG |=> rdata_o[POLL_BIT] == !job.wbit);

endmodule

// File: tb/flash_busy_status_tb.sv
`timescale 1ns/1ps
module flash_busy_status_tb;

    localparam int DW     = 16;
    localparam int D_PROG = 40;
    localparam int D_SECT = 90;
    localparam int D_BLK  = 100;
    localparam int D_CHIP = 160;
    localparam int SETTLE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'd0;
    logic          prog_bit_i = 1'b0;
    logic          rd_i = 1'b0;
    logic [DW-1:0] array_i = '0;
    logic [DW-1:0] rdata_o;
    logic          busy_o;
    logic          done_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_busy_status #(
        .DATA_W(DW), .PROG_CYC(D_PROG), .SECT_CYC(D_SECT),
        .BLK_CYC(D_BLK), .CHIP_CYC(D_CHIP), .SETTLE_CYC(SETTLE)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .prog_bit_i(prog_bit_i), .rd_i(rd_i), .array_i(array_i),
        .rdata_o(rdata_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int dur_of(input logic [1:0] op);
        case (op)
            2'd0:    return D_PROG;
            2'd1:    return D_SECT;
            2'd2:    return D_BLK;
            default: return D_CHIP;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [DW-1:0] exp_rd = '0;

    // One full operation: start, then walk the busy, settle and idle phases.
    task automatic run_op(input logic [1:0] op, input logic wb, input int rd_pct,
                          input int stray_pct, input bit stray_last);
        int  dur;
        int  busy_cnt;
        int  done_cnt;
        bit  tog;
        bit  stray_seen;
        bit  did_rd;
        int  last_ph;
        dur = dur_of(op);
        busy_cnt = 0;
        done_cnt = 0;
        tog = 1'b0;
        stray_seen = 1'b0;
        did_rd = 1'b0;
        last_ph = 0;
        start_i = 1'b1;
        op_i = op;
        prog_bit_i = wb;
        rd_i = 1'b0;
        @(negedge clk);
        for (int c = 1; c <= dur + SETTLE + 4; c++) begin
            start_i = 1'b0;
            rd_i = 1'b0;
            if (busy_o) busy_cnt++;
            if (done_o) done_cnt++;
            chk("R2 busy level", {15'd0, busy_o}, {15'd0, (c <= dur)});
            chk("R3 done pulse", {15'd0, done_o}, {15'd0, (c == dur + 1)});
            if (!did_rd) begin
                chk("R11 hold without read", rdata_o, exp_rd);
            end else if (last_ph == 1) begin
                chk(op == 2'd0 ? "R4 program poll bit" : "R5 erase poll bit",
                    {15'd0, rdata_o[7]}, {15'd0, exp_rd[7]});
                chk("R6 toggle bit", {15'd0, rdata_o[6]}, {15'd0, exp_rd[6]});
                chk("R7 stale bits", rdata_o & 16'hFF3F, exp_rd & 16'hFF3F);
            end else if (last_ph == 2) begin
                chk("R8 settle read", rdata_o, exp_rd);
            end else begin
                chk("R9 array pass", rdata_o, exp_rd);
            end
            did_rd = ($urandom_range(99) < rd_pct);
            rd_i = did_rd;
            array_i = DW'($urandom);
            if (c <= dur && (($urandom_range(99) < stray_pct) || (stray_last && c == dur))) begin
                start_i = 1'b1;
                op_i = 2'($urandom);
                prog_bit_i = 1'($urandom);
                stray_seen = 1'b1;
            end
            if (did_rd) begin
                if (c <= dur) begin
                    last_ph = 1;
                    tog = ~tog;
                    exp_rd[7] = (op == 2'd0) ? ~wb : 1'b0;
                    exp_rd[6] = tog;
                end else if (op == 2'd0 && c <= dur + SETTLE) begin
                    last_ph = 2;
                    exp_rd[7] = wb;
                    exp_rd[6] = tog;
                end else begin
                    last_ph = 0;
                    exp_rd = array_i;
                end
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        rd_i = 1'b0;
        chk(stray_seen ? "R10 busy length with stray start" : "R2 busy length",
            DW'(busy_cnt), DW'(dur));
        chk("R3 done count", DW'(done_cnt), 16'd1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 busy after reset", {15'd0, busy_o}, 16'd0);
        chk("R1 done after reset", {15'd0, done_o}, 16'd0);
        chk("R1 rdata after reset", rdata_o, 16'd0);
        // Directed: every op, reads on every cycle, late stray start on a program
        run_op(2'd0, 1'b1, 100, 0, 1'b1);
        run_op(2'd0, 1'b0, 100, 0, 1'b0);
        run_op(2'd1, 1'b1, 100, 0, 1'b1);
        run_op(2'd2, 1'b0, 100, 0, 1'b0);
        run_op(2'd3, 1'b1, 100, 0, 1'b0);
        // Sparse reads: toggle must advance only on strobes
        run_op(2'd0, 1'b1, 15, 0, 1'b0);
        // Constrained random mix
        for (int i = 0; i < 16; i++) begin
            run_op(2'($urandom), 1'($urandom), 20 + int'($urandom_range(70)),
                   int'($urandom_range(10)), 1'b0);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule